// File: doc/BRIEF.md
# Single-Line Interrupt Gate

This block sits between one external interrupt wire and a parent interrupt controller. The wire is first re-timed into the local clock domain. It is then judged against a trigger style chosen by software: level or edge, with either polarity. A qualifying event sets a sticky pending flag. The flag, masked by an enable bit, drives a registered request toward the parent controller.

Software reaches the block through a small 32-bit register window with three registers. A control register holds the trigger style. A pending register reports the flag, and writing a one to its bit 0 acknowledges the flag. An enable register gates the request. The enable register sits at one of two offsets, and a build-time parameter picks which one, so a single design serves both address-map variants. The usual service sequence is to disable, acknowledge, handle and re-enable. A request that arrives while the request is masked is kept and is never dropped.

Top module: `line_irq_gate`

## Requirements
- R1: Out of reset the control, pending and enable registers all read 0, `irqReq` is low, and the synchroniser holds the inactive-high value. The default trigger style is therefore active-low level, and it does not fire while `irqIn` is held high.
- R2: A read of any offset returns data on `busRdata` with `busRvalid` high exactly one cycle after the request. Unmapped offsets read as 0.
- R3: Bits [1:0] of the control register at offset 0x00 select the trigger style: 0 active-low level, 1 falling edge, 2 active-high level, 3 rising edge. The input passes two synchroniser flops, so the pending flag sets on the third rising clock edge after `irqIn` changes.
- R4: In the edge styles, the pending flag stays set after the input returns to idle and remains set until it is acknowledged.
- R5: In the level styles, an acknowledge clears the pending flag for one cycle. If the input is still active, the flag sets again on the following cycle.
- R6: Writing 1 to bit 0 of the pending register at offset 0x04 clears the flag. Writing 0 there has no effect. A read of that register returns the flag in bit 0 and 0 when nothing is pending.
- R7: In an edge style, an edge detected in the same cycle as an acknowledge wins, and the flag stays set.
- R8: Bit 0 of the enable register gates the request. The register sits at offset 0x08 when parameter `ENA_ALT` is 0 and at offset 0x34 when it is 1. Writes to the offset that is not selected are ignored, and that offset reads as 0.
- R9: `irqReq` is a register loaded with the pending flag ANDed with the enable bit, so it follows either of them by one cycle.
- R10: The pending flag is kept while the request is masked, and re-enabling raises `irqReq` without a new input event. An acknowledge issued while masked clears the flag, so a later re-enable raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 1 | External interrupt line, asynchronous |
| busSel | input | 1 | Register access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, one cycle after the request |
| busRvalid | output | 1 | Read data valid |
| irqReq | output | 1 | Registered request to the parent controller |

## Verification
The bench targets four corner cases:
- An acknowledge that coincides with a fresh edge: a design that gives the acknowledge priority loses that interrupt for good.
- An acknowledge in level style with the line still asserted: a design that fails to re-set the flag leaves a stuck source unserviced, and one that never clears it hides the acknowledge altogether.
- Masking and unmasking around a pending event: a design that clears the flag on disable, or that gates the flag itself rather than the output, drops the request.
- A switch of trigger style while the line is static, and writes to the enable offset that is not selected: a poorly built design raises a phantom edge in the first case and gains a second enable alias in the second.

Long random sequences then compare every cycle of traffic against a cycle model of the requirements.

// File: rtl/line_irq_gate_pkg.sv
package line_irq_gate_pkg;

  // Trigger style: bit 1 = high polarity, bit 0 = edge sensitive.
  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'd0,
    TRIG_EDGE_FALL  = 2'd1,
    TRIG_LEVEL_HIGH = 2'd2,
    TRIG_EDGE_RISE  = 2'd3
  } trig_mode_e;

  // Strobes and settings passed from register control to the datapath.
  typedef struct packed {
    logic       ackPulse;
    logic       enable;
    trig_mode_e mode;
  } gate_ctrl_t;

  localparam int unsigned OFS_CTRL       = 32'h00;
  localparam int unsigned OFS_PEND       = 32'h04;
  localparam int unsigned OFS_ENA_NARROW = 32'h08;
  localparam int unsigned OFS_ENA_WIDE   = 32'h34;

endpackage

// File: rtl/line_irq_gate_ctrl.sv
module line_irq_gate_ctrl
  import line_irq_gate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter bit          ENA_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pendFlag,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output gate_ctrl_t        ctrlOut
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(OFS_PEND);

  logic [ADDR_W-1:0] enaAddr;

  // The variant parameter picks where the enable register is decoded.
  generate
    if (ENA_ALT) begin : g_ena_wide
      assign enaAddr = ADDR_W'(OFS_ENA_WIDE);
    end else begin : g_ena_narrow
      assign enaAddr = ADDR_W'(OFS_ENA_NARROW);
    end
  endgenerate

  logic       hitCtrl, hitPend, hitEna;
  logic       wrAcc, rdAcc;
  trig_mode_e modeQ;
  logic       enQ;
  logic [DATA_W-1:0] rdNext;
  logic       unusedBits;

  assign hitCtrl = (busAddr == CTRL_ADDR);
  assign hitPend = (busAddr == PEND_ADDR);
  assign hitEna  = (busAddr == enaAddr);
  assign wrAcc   = busSel &  busWr;
  assign rdAcc   = busSel & ~busWr;

  assign unusedBits = ^busWdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= TRIG_LEVEL_LOW;
      enQ   <= 1'b0;
    end else begin
      if (wrAcc && hitCtrl) modeQ <= trig_mode_e'(busWdata[1:0]);
      if (wrAcc && hitEna)  enQ   <= busWdata[0];
    end
  end

  always_comb begin
    rdNext = '0;
    if (hitCtrl)      rdNext[1:0] = modeQ;
    else if (hitPend) rdNext[0]   = pendFlag;
    else if (hitEna)  rdNext[0]   = enQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRdata  <= rdAcc ? rdNext : '0;
      busRvalid <= rdAcc;
    end
  end

  assign ctrlOut.ackPulse = wrAcc & hitPend & busWdata[0];
  assign ctrlOut.enable   = enQ;
  assign ctrlOut.mode     = modeQ;

endmodule

// File: rtl/line_irq_gate_dp.sv
module line_irq_gate_dp
  import line_irq_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irqIn,
  input  gate_ctrl_t ctrlIn,
  output logic       pendFlag,
  output logic       irqReq
);

  // Synchroniser resets to the idle-high value so the default
  // active-low style sees no event during reset release.
  logic [SYNC_STAGES-1:0] syncQ;
  logic lineNow, linePrev;
  logic highPol, edgeStyle;
  logic lineActive, prevActive, edgeHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ    <= '1;
      linePrev <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], irqIn};
      linePrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineNow    = syncQ[SYNC_STAGES-1];
  assign highPol    = ctrlIn.mode[1];
  assign edgeStyle  = ctrlIn.mode[0];
  assign lineActive = highPol ? lineNow  : ~lineNow;
  assign prevActive = highPol ? linePrev : ~linePrev;
  assign edgeHit    = lineActive & ~prevActive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendFlag <= 1'b0;
    end else if (edgeStyle) begin
      pendFlag <= edgeHit | (pendFlag & ~ctrlIn.ackPulse);
    end else if (ctrlIn.ackPulse) begin
      pendFlag <= 1'b0;
    end else begin
      pendFlag <= pendFlag | lineActive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqReq <= 1'b0;
    else        irqReq <= pendFlag & ctrlIn.enable;
  end

endmodule

// File: rtl/line_irq_gate.sv
module line_irq_gate
  import line_irq_gate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter bit          ENA_ALT     = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              irqReq
);

  gate_ctrl_t gateCtrl;
  logic       pendFlag;

  line_irq_gate_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ENA_ALT(ENA_ALT)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .pendFlag (pendFlag),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .ctrlOut  (gateCtrl)
  );

  line_irq_gate_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .irqIn   (irqIn),
    .ctrlIn  (gateCtrl),
    .pendFlag(pendFlag),
    .irqReq  (irqReq)
  );

endmodule

// File: rtl/line_irq_gate_chk.sv
module line_irq_gate_chk
  import line_irq_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busSel,
  input logic       busWr,
  input logic       busRvalid,
  input logic       pendFlag,
  input gate_ctrl_t gateCtrl,
  input logic       irqReq
);

  // R2: every read request is answered on the next cycle
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWr) |=> busRvalid);

  // R4: the flag only drops through an acknowledge
  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pendFlag && !gateCtrl.ackPulse) |=> pendFlag);

  // R5: a level-style acknowledge empties the flag for one cycle
  assert_level_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gateCtrl.ackPulse && !gateCtrl.mode[0]) |=> !pendFlag);

  // R9: a masked block raises no request on the next cycle
  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gateCtrl.enable |=> !irqReq);

  // R10: a rising request always has a flag behind it
  assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqReq) |-> $past(pendFlag));

endmodule

bind line_irq_gate line_irq_gate_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busSel   (busSel),
  .busWr    (busWr),
  .busRvalid(busRvalid),
  .pendFlag (pendFlag),
  .gateCtrl (gateCtrl),
  .irqReq   (irqReq)
);

// File: tb/line_irq_gate_tb_top.sv
`timescale 1ns/1ps
module line_irq_gate_tb_top;

  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam bit          ENA_ALT = 1'b0;
  localparam logic [7:0]  A_CTRL  = 8'h00;
  localparam logic [7:0]  A_PEND  = 8'h04;
  localparam logic [7:0]  A_ENA   = ENA_ALT ? 8'h34 : 8'h08;
  localparam logic [7:0]  A_OTHER = ENA_ALT ? 8'h08 : 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irqIn = 1'b1;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic busRvalid;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  line_irq_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENA_ALT(ENA_ALT)) dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .irqReq(irqReq)
  );

  // Cycle model built from the requirements.
  logic ms1, ms2, mPrev, mPend, mEn, mReq, mRvalid;
  logic [1:0] mMode;
  logic [31:0] mRdata;

  function automatic logic [31:0] modelRead(input logic [7:0] a, input logic [1:0] md,
                                            input logic pd, input logic en);
    if (a == A_CTRL) return {30'd0, md};
    if (a == A_PEND) return {31'd0, pd};
    if (a == A_ENA)  return {31'd0, en};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 <= 1'b1; ms2 <= 1'b1; mPrev <= 1'b1; mPend <= 1'b0;
      mEn <= 1'b0; mReq <= 1'b0; mMode <= 2'd0; mRdata <= 32'd0; mRvalid <= 1'b0;
    end else begin
      logic act, pact, ack;
      act  = mMode[1] ? ms2 : ~ms2;
      pact = mMode[1] ? mPrev : ~mPrev;
      ack  = busSel && busWr && busAddr == A_PEND && busWdata[0];
      ms1 <= irqIn; ms2 <= ms1; mPrev <= ms2;
      if (mMode[0]) mPend <= (act && !pact) || (mPend && !ack);
      else          mPend <= ack ? 1'b0 : (mPend || act);
      mReq <= mPend && mEn;
      if (busSel && busWr && busAddr == A_CTRL) mMode <= busWdata[1:0];
      if (busSel && busWr && busAddr == A_ENA)  mEn <= busWdata[0];
      mRvalid <= busSel && !busWr;
      mRdata  <= (busSel && !busWr) ? modelRead(busAddr, mMode, mPend, mEn) : 32'd0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
    check("R2 rvalid", {31'd0, busRvalid}, 32'd1);
  endtask

  task automatic expectRead(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check("R1 irqReq", {31'd0, irqReq}, 32'd0);
    expectRead("R1 ctrl", A_CTRL, 0);
    expectRead("R1 pend", A_PEND, 0);
    expectRead("R1 ena", A_ENA, 0);
    // R2 unmapped offset
    expectRead("R2 unmapped", 8'h10, 0);
    idle(1);
    check("R2 rvalid idle", {31'd0, busRvalid}, 32'd0);

    // R8 enable, R3 active-low level
    busWrite(A_ENA, 1);
    expectRead("R8 ena", A_ENA, 1);
    irqIn = 1'b0;
    idle(2);
    check("R3 not before sync", {31'd0, irqReq}, 32'd0);
    idle(2);
    check("R9 req level low", {31'd0, irqReq}, 32'd1);
    expectRead("R3 pend level low", A_PEND, 1);

    // R5 level ack while active
    busWrite(A_PEND, 1);
    expectRead("R5 cleared one cycle", A_PEND, 0);
    expectRead("R5 set again", A_PEND, 1);
    // R6 write of 0 does nothing
    busWrite(A_PEND, 0);
    expectRead("R6 zero write ignored", A_PEND, 1);
    irqIn = 1'b1;
    idle(3);
    busWrite(A_PEND, 1);
    idle(2);
    expectRead("R6 ack clears", A_PEND, 0);

    // R3 active-high level
    busWrite(A_CTRL, 2);
    expectRead("R3 ctrl readback", A_CTRL, 2);
    idle(2);
    expectRead("R3 pend level high", A_PEND, 1);
    irqIn = 1'b0;
    idle(3);
    busWrite(A_PEND, 1);
    idle(1);
    expectRead("R5 inactive stays clear", A_PEND, 0);

    // R4 rising edge latch
    busWrite(A_CTRL, 3);
    irqIn = 1'b1; idle(4);
    irqIn = 1'b0; idle(4);
    expectRead("R4 latched after pulse", A_PEND, 1);
    check("R9 req edge", {31'd0, irqReq}, 32'd1);
    busWrite(A_PEND, 1);
    expectRead("R4 ack clears", A_PEND, 0);
    idle(1);
    check("R9 req dropped", {31'd0, irqReq}, 32'd0);

    // R3 falling style: a rising edge must not fire
    busWrite(A_CTRL, 1);
    irqIn = 1'b1; idle(4);
    expectRead("R3 rising ignored in falling", A_PEND, 0);
    irqIn = 1'b0; idle(4);
    expectRead("R3 falling fires", A_PEND, 1);

    // R7 edge coinciding with ack
    irqIn = 1'b1; idle(4);
    irqIn = 1'b0;
    idle(2);
    busWrite(A_PEND, 1);
    expectRead("R7 edge beats ack", A_PEND, 1);
    busWrite(A_PEND, 1);
    expectRead("R7 later ack clears", A_PEND, 0);

    // R10 kept while masked
    busWrite(A_ENA, 0);
    irqIn = 1'b1; idle(4);
    irqIn = 1'b0; idle(4);
    check("R10 masked req", {31'd0, irqReq}, 32'd0);
    expectRead("R10 pend kept", A_PEND, 1);
    busWrite(A_ENA, 1);
    idle(1);
    check("R10 req on re-enable", {31'd0, irqReq}, 32'd1);
    busWrite(A_ENA, 0);
    busWrite(A_PEND, 1);
    busWrite(A_ENA, 1);
    idle(2);
    check("R10 ack while masked", {31'd0, irqReq}, 32'd0);

    // R8 the unselected enable offset is ignored
    busWrite(A_ENA, 0);
    busWrite(A_OTHER, 1);
    expectRead("R8 other offset no effect", A_ENA, 0);
    expectRead("R8 other offset reads 0", A_OTHER, 0);

    // Random traffic against the cycle model (R2, R3, R7, R9)
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0, 1: irqIn = ~irqIn;
        2: begin busSel = 1'b1; busWr = 1'b1; busAddr = A_CTRL; busWdata = $urandom; end
        3: begin busSel = 1'b1; busWr = 1'b1; busAddr = A_ENA;  busWdata = $urandom; end
        4: begin busSel = 1'b1; busWr = 1'b1; busAddr = A_PEND; busWdata = $urandom; end
        5: begin
             busSel = 1'b1; busWr = 1'b0;
             case ($urandom % 4)
               0: busAddr = A_CTRL;
               1: busAddr = A_PEND;
               2: busAddr = A_ENA;
               default: busAddr = 8'($urandom);
             endcase
           end
        default: ;
      endcase
      @(posedge clk); @(negedge clk);
      busSel = 1'b0; busWr = 1'b0;
      check("R9 random irqReq", {31'd0, irqReq}, {31'd0, mReq});
      check("R2 random rvalid", {31'd0, busRvalid}, {31'd0, mRvalid});
      check("R3 random rdata", busRdata, mRdata);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule